// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block is a synchronous single-port memory whose interface never needs an idle cycle between a read and a write. A command is taken on each enabled rising clock edge. Write data trails its address by one edge and is parked in a late-write register, which is merged into the storage array on the following enabled edge. Read data is not registered at the output: the read address is captured on the edge and the word flows out combinationally during the cycle that follows.

Because a write is still in flight when later commands arrive, the read path compares its address with the parked write and substitutes the parked byte lanes. A read therefore always sees the most recent value written. An active-low clock enable turns an edge into a pause in which nothing moves. Three chip-select inputs gate every command. An output drive flag stands in for the tri-state data bus.

Top module: `ftsram`

## Requirements
- R1: The device is selected on an enabled edge only when `sel_a_n` = 0, `sel_b_n` = 0 and `sel_c` = 1. Any other combination is a deselect: no command is taken and `q_drive` is 0 in the following cycle.
- R2: For a selected, enabled edge the command is coded as follows. `cmd_load_n` = 0 with `op_read` = 1 is a read. `cmd_load_n` = 0 with `op_read` = 0 is a write. `cmd_load_n` = 1 is a no-op, whatever `op_read` is.
- R3: An edge with `clk_en_n` = 1 is ignored. No command is taken, no data is captured, nothing is committed, and `rdata` and `q_drive` keep their values.
- R4: For a write, the address is taken on enabled edge N and `wdata` is taken on the next enabled edge. The word is written into the array on the enabled edge after that.
- R5: `lane_wr_n[i]` is active low and enables bits [9i+8:9i]. It is sampled together with the write address. Lanes whose enable is high keep their old contents.
- R6: For a read taken on enabled edge N, `rdata` shows the addressed word during the cycle after edge N. The value holds until the next enabled edge, including across stalled edges.
- R7: A read returns the newest data for its address, including enabled lanes still held in the late-write register and not yet in the array.
- R8: `q_drive` is 1 only in the cycle after a selected read. It is 0 after write, no-op and deselect edges, and it stays 0 through consecutive deselects.
- R9: A no-op or deselect edge neither reads nor writes the array on its own behalf. It still captures the data of a write taken on the previous enabled edge, and it still commits a pending late write.
- R10: Back-to-back writes, including repeated writes to one address with different lane enables, lose no data.
- R11: While `rst_n` is 0 at an edge, the array is cleared, no write is pending and `q_drive` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high makes the edge a pause |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| cmd_load_n | input | 1 | Low loads a new command; high is a no-op |
| op_read | input | 1 | 1 = read, 0 = write |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Late write data, one enabled edge after its address |
| rdata | output | LANES*LANE_W | Flow-through read data |
| q_drive | output | 1 | High when the read data would drive the bus |

## Verification
The interesting case is a late-write commit or capture landing on the same edge as a read of the same address. On that edge the array is being updated, the late-write register is being reloaded, and a new read address is captured. The bench provokes this with a write followed at once by a read of that address, writes separated from their data by stalls and deselects, and random short-address traffic. It judges each result against a behavioural array that applies every write at the moment its data is captured.

// File: rtl/ftsram_pkg.sv
// Package: shared command coding for the flow-through late-write SRAM.
// Assumes: nothing beyond the decode order documented in ftsram_cmd_decode.
package ftsram_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_NOP   = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_e;

endpackage

// File: rtl/ftsram_cmd_decode.sv
// Module: ftsram_cmd_decode
// Turns the raw control pins into one command and an edge-enable strobe.
// Assumes: all pins are sampled on the same rising edge by the consumers;
// a selected device with the load input high performs a no-op.
module ftsram_cmd_decode
    import ftsram_pkg::*;
(
    input  logic clk_en_n,
    input  logic sel_a_n,
    input  logic sel_b_n,
    input  logic sel_c,
    input  logic cmd_load_n,
    input  logic op_read,
    output logic step_en,
    output cmd_e cmd
);

    logic chip_on;

    // Purpose: decode select, load and direction into a single command.
    always_comb begin
        step_en = !clk_en_n;
        chip_on = !sel_a_n && !sel_b_n && sel_c;
        if (!chip_on)
            cmd = CMD_DESEL;
        else if (cmd_load_n)
            cmd = CMD_NOP;
        else if (op_read)
            cmd = CMD_READ;
        else
            cmd = CMD_WRITE;
    end

endmodule

// File: rtl/ftsram_write_pipe.sv
// Module: ftsram_write_pipe
// Two-stage write path: an address stage that holds a write's address and
// lane enables, and a late-write register that holds the word once its data
// arrives. The late write is committed on the next enabled edge.
// Assumes: all state moves only when step_en is high.
module ftsram_write_pipe
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  cmd_e                    cmd,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    lw_valid,
    output logic [ADDR_W-1:0]       lw_addr,
    output logic [LANES-1:0]        lw_lane_n,
    output logic [LANES*LANE_W-1:0] lw_data,
    output logic                    commit_we
);

    localparam int DW = LANES * LANE_W;

    logic              wa_valid;
    logic [ADDR_W-1:0] wa_addr;
    logic [LANES-1:0]  wa_lane_n;

    // Purpose: hold the address and lane enables of a write taken this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_valid  <= 1'b0;
            wa_addr   <= '0;
            wa_lane_n <= '1;
        end else if (step_en) begin
            wa_valid  <= (cmd == CMD_WRITE);
            wa_addr   <= addr;
            wa_lane_n <= lane_wr_n;
        end
    end

    // Purpose: pair the trailing data word with its parked address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_valid  <= 1'b0;
            lw_addr   <= '0;
            lw_lane_n <= '1;
            lw_data   <= '0;
        end else if (step_en) begin
            lw_valid  <= wa_valid;
            lw_addr   <= wa_addr;
            lw_lane_n <= wa_lane_n;
            lw_data   <= wdata;
        end
    end

    // Purpose: a parked word is written to the array on the next enabled edge.
    always_comb commit_we = step_en && lw_valid;

    assert_data_follows_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && wa_valid) |=> (lw_valid && lw_addr == $past(wa_addr)));

    assert_late_write_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !wa_valid) |=> !lw_valid);

    assert_stall_freezes_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(lw_valid) && $stable(lw_data) && $stable(wa_valid)));

    logic [DW-1:0] unused_width_probe;
    always_comb unused_width_probe = lw_data;

endmodule

// File: rtl/ftsram_store.sv
// Module: ftsram_store
// Storage array split into one memory per byte lane, with an asynchronous
// read port and a lane-masked synchronous write port.
// Assumes: the write strobe is already gated by the edge enable.
module ftsram_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wlane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Purpose: clear on reset, otherwise write this lane when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++)
                    lane_mem[i] <= '0;
            end else if (we && !wlane_n[g]) begin
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Purpose: flow-through read of this lane.
        always_comb rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];

        assert_lane_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !wlane_n[g]) |=> (lane_mem[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/ftsram_read_port.sv
// Module: ftsram_read_port
// Captures the read address and drive flag on an enabled edge and produces
// the newest word by overlaying the late-write register on the array output.
// Assumes: the late-write register holds the only write not yet in the array.
module ftsram_read_port
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  cmd_e                    cmd,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic                    lw_valid,
    input  logic [ADDR_W-1:0]       lw_addr,
    input  logic [LANES-1:0]        lw_lane_n,
    input  logic [LANES*LANE_W-1:0] lw_data,
    output logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    q_drive
);

    logic [ADDR_W-1:0] rd_addr_q;
    logic              drive_q;
    logic              lw_hit;

    // Purpose: take a new read address and drive flag on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
            drive_q   <= 1'b0;
        end else if (step_en) begin
            drive_q <= (cmd == CMD_READ);
            if (cmd == CMD_READ)
                rd_addr_q <= addr;
        end
    end

    // Purpose: detect that the parked write targets the word being read.
    always_comb begin
        raddr   = rd_addr_q;
        lw_hit  = lw_valid && (lw_addr == rd_addr_q);
        q_drive = drive_q;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        // Purpose: pick the parked lane over the array lane when it is newer.
        always_comb begin
            if (lw_hit && !lw_lane_n[g])
                rdata[g*LANE_W +: LANE_W] = lw_data[g*LANE_W +: LANE_W];
            else
                rdata[g*LANE_W +: LANE_W] = arr_data[g*LANE_W +: LANE_W];
        end
    end

    assert_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cmd == CMD_READ) |=> q_drive);

    assert_drive_off_otherwise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cmd != CMD_READ) |=> !q_drive);

    assert_stall_holds_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(q_drive) && $stable(rd_addr_q) && $stable(rdata)));

endmodule

// File: rtl/ftsram.sv
// Module: ftsram (top)
// Flow-through late-write SRAM: command decode, two-stage write pipe,
// per-lane storage and a bypassing read port.
// Assumes: output enable permanently asserted; q_drive marks the cycles in
// which the data bus would be driven.
module ftsram
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    cmd_load_n,
    input  logic                    op_read,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    q_drive
);

    localparam int DW = LANES * LANE_W;

    logic              step_en;
    cmd_e              cmd;
    logic              lw_valid;
    logic [ADDR_W-1:0] lw_addr;
    logic [LANES-1:0]  lw_lane_n;
    logic [DW-1:0]     lw_data;
    logic              commit_we;
    logic [ADDR_W-1:0] raddr;
    logic [DW-1:0]     arr_data;

    ftsram_cmd_decode u_decode (
        .clk_en_n   (clk_en_n),
        .sel_a_n    (sel_a_n),
        .sel_b_n    (sel_b_n),
        .sel_c      (sel_c),
        .cmd_load_n (cmd_load_n),
        .op_read    (op_read),
        .step_en    (step_en),
        .cmd        (cmd)
    );

    ftsram_write_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .cmd       (cmd),
        .addr      (addr),
        .lane_wr_n (lane_wr_n),
        .wdata     (wdata),
        .lw_valid  (lw_valid),
        .lw_addr   (lw_addr),
        .lw_lane_n (lw_lane_n),
        .lw_data   (lw_data),
        .commit_we (commit_we)
    );

    ftsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (commit_we),
        .waddr   (lw_addr),
        .wlane_n (lw_lane_n),
        .wdata   (lw_data),
        .raddr   (raddr),
        .rdata   (arr_data)
    );

    ftsram_read_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rport (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .cmd       (cmd),
        .addr      (addr),
        .arr_data  (arr_data),
        .lw_valid  (lw_valid),
        .lw_addr   (lw_addr),
        .lw_lane_n (lw_lane_n),
        .lw_data   (lw_data),
        .raddr     (raddr),
        .rdata     (rdata),
        .q_drive   (q_drive)
    );

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && (sel_a_n || sel_b_n || !sel_c)) |=> !q_drive);

    assert_noop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sel_a_n && !sel_b_n && sel_c && cmd_load_n) |=> !q_drive);

endmodule

// File: tb/ftsram_bench.sv
module ftsram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int NL    = 2;
    localparam int LW    = 9;
    localparam int DW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n;
    logic          sel_a_n, sel_b_n, sel_c;
    logic          cmd_load_n, op_read;
    logic [NL-1:0] lane_wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          q_drive;

    always #(CLK_PERIOD/2) clk = ~clk;

    ftsram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_ftsram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .cmd_load_n(cmd_load_n), .op_read(op_read), .lane_wr_n(lane_wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .q_drive(q_drive)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference: writes land here as soon as their data is taken.
    logic [DW-1:0] ref_mem [DEPTH];
    bit            m_pend;
    int            m_paddr;
    logic [NL-1:0] m_plane;
    bit            m_drive;
    logic [DW-1:0] m_q;

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit stall, bit an, bit bn, bit c, bit ldn, bit rd,
                        int a, logic [NL-1:0] lanes, logic [DW-1:0] wd);
        clk_en_n   = stall;
        sel_a_n    = an;
        sel_b_n    = bn;
        sel_c      = c;
        cmd_load_n = ldn;
        op_read    = rd;
        addr       = a[AW-1:0];
        lane_wr_n  = lanes;
        wdata      = wd;
        @(posedge clk);
        if (!stall) begin
            if (m_pend)
                for (int l = 0; l < NL; l++)
                    if (!m_plane[l]) ref_mem[m_paddr][l*LW +: LW] = wd[l*LW +: LW];
            m_drive = !an && !bn && c && !ldn && rd;
            if (m_drive) m_q = ref_mem[a];
            m_pend  = !an && !bn && c && !ldn && !rd;
            m_paddr = a;
            m_plane = lanes;
        end
        @(negedge clk);
        check(tag, "q_drive", DW'(q_drive), DW'(m_drive));
        if (m_drive) check(tag, "rdata", rdata, m_q);
    endtask

    task automatic do_write(string tag, int a, logic [NL-1:0] lanes, logic [DW-1:0] wd);
        step(tag, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, lanes, wd);
    endtask

    task automatic do_read(string tag, int a, logic [DW-1:0] wd);
        step(tag, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, 2'b11, wd);
    endtask

    task automatic do_nop(string tag, logic [DW-1:0] wd);
        step(tag, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3, 2'b00, wd);
    endtask

    task automatic do_stall(string tag, logic [DW-1:0] wd);
        step(tag, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9, 2'b00, wd);
    endtask

    task automatic do_desel(string tag, int kind, logic [DW-1:0] wd);
        step(tag, 1'b0, kind == 0, kind == 1, kind != 2, 1'b0, 1'b0, 5, 2'b00, wd);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        m_pend = 0; m_paddr = 0; m_plane = '1; m_drive = 0; m_q = '0;
        rst_n = 1'b0; clk_en_n = 1'b0; sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0;
        cmd_load_n = 1'b1; op_read = 1'b0; lane_wr_n = '1; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        check("R11", "q_drive after reset", DW'(q_drive), '0);
        rst_n = 1'b1;

        // R11: untouched word reads as zero
        do_read("R11", 17, 18'h0);

        // Main sequence: write, read, stall, read, write, stall, no-op, read, deselect x2
        do_write("R4", 3, 2'b00, 18'h0);
        do_read("R7", 3, 18'h2A5C3);          // data taken on the read edge, bypassed
        do_stall("R3", 18'h3FFFF);            // output held
        do_read("R6", 3, 18'h11111);          // now from the array
        do_write("R4", 7, 2'b00, 18'h0);
        do_stall("R3", 18'h00BAD);            // data deferred past the pause
        do_nop("R9", 18'h1C0DE);              // data taken, commit follows
        do_read("R9", 7, 18'h0);
        do_desel("R8", 0, 18'h0);
        do_desel("R8", 1, 18'h0);

        // R1: every non-select combination is ignored
        do_desel("R1", 2, 18'h0);
        do_read("R1", 5, 18'h0);

        // R2: load high is a no-op even with write direction
        do_nop("R2", 18'h0);
        do_read("R2", 3, 18'h0);

        // R5: lane 0 only, then lane 1 only
        do_write("R5", 12, 2'b10, 18'h0);
        do_write("R5", 12, 2'b01, 18'h3FFFF);
        do_read("R5", 12, 18'h15555);
        do_read("R5", 12, 18'h0);

        // R10: back-to-back writes, same and different addresses
        do_write("R10", 20, 2'b00, 18'h0);
        do_write("R10", 20, 2'b10, 18'h0AAAA);
        do_write("R10", 21, 2'b00, 18'h1F00F);
        do_write("R10", 22, 2'b00, 18'h2468A);
        do_read("R10", 20, 18'h13579);
        do_read("R10", 21, 18'h0);
        do_read("R10", 22, 18'h0);

        // R7: write, pause, then read of the same word on the data edge
        do_write("R7", 30, 2'b00, 18'h0);
        do_stall("R3", 18'h00001);
        do_read("R7", 30, 18'h3C3C3);
        do_stall("R6", 18'h0);
        do_stall("R6", 18'h0);

        // R9: deselect between a write address and its data
        do_write("R9", 40, 2'b00, 18'h0);
        do_desel("R9", 0, 18'h2BEEF);
        do_read("R9", 40, 18'h0);

        // Random traffic over a few addresses to force collisions
        for (int n = 0; n < 500; n++) begin
            int op = $urandom_range(0, 5);
            int a  = $urandom_range(0, 3);
            logic [DW-1:0] d = DW'($urandom);
            logic [NL-1:0] ln = NL'($urandom);
            case (op)
                0: do_write("R10", a, ln, d);
                1: do_read("R7", a, d);
                2: do_nop("R9", d);
                3: do_stall("R3", d);
                4: do_desel("R1", $urandom_range(0, 2), d);
                default: do_read("R6", a, d);
            endcase
        end

        finish_run();
    end

endmodule